// File: doc/BRIEF.md
# Branch Squash and Redirect Controller

This controller sits next to an in-order pipeline and decides what happens to the instructions fetched behind a control-transfer instruction. A control transfer is a branch, a call or a return. The controller sees it when it reaches decode. The condition and destination of that instruction are only known when it reaches execute, which lies `DEPTH` stages after fetch.

A run-time policy input selects one of three ways to handle the younger instructions:

- **Flush:** every younger instruction is discarded and fetch is held until the transfer resolves.
- **Delay slots:** the `DEPTH` younger instructions always complete.
- **Annul on taken:** younger instructions keep flowing. They are discarded only if the transfer turns out to be taken. Interrupts are masked while the outcome is open.

Pipeline stages are numbered 0 (fetch), 1 (decode), up to `DEPTH-1`. Execute is stage `DEPTH`. The pipeline reports which of stages 0 to `DEPTH-1` hold a valid instruction, plus the flow kind of the instruction in decode. While the transfer is in execute, it also supplies the resolved outcome, the destination address and the sequential address. The controller returns:

- a kill bit per stage, which drops that instruction as it advances;
- a one-cycle redirect strobe with the address to fetch next;
- a fetch hold;
- an interrupt mask;
- an error flag for a transfer that arrives in the shadow of another.

Top module: `branch_squash_ctl`

## Requirements
- R1: After synchronous reset, with no valid stage, all of the following are low: every kill bit, the redirect strobe, the fetch hold, the interrupt mask and the error flag.
- R2: A valid decode-stage instruction with flow code 1 (branch), 2 (call) or 3 (return) is tracked in the same way. Code 0 is an ordinary instruction. A tracked transfer resolves `DEPTH-1` cycles after it is seen in decode.
- R3: Policy code 0 is flush; code 3 also selects flush. In flush, the fetch hold is high from the cycle the transfer is in decode through the cycle it resolves. During those cycles every valid stage younger than the transfer is killed.
- R4: In flush, the redirect strobe fires in the resolve cycle in both cases. Its address is the destination when the transfer is taken and the sequential address when it is not. Exactly `DEPTH` fetch slots are lost.
- R5: Policy code 1 is delay slots. Nothing is killed, fetch is never held, and the `DEPTH` instructions after the transfer always complete.
- R6: With delay slots, a taken transfer redirects to the destination in the resolve cycle. The instruction `DEPTH+1` places after the transfer therefore comes from the destination only when the transfer is taken. A not-taken transfer gives no redirect.
- R7: Policy code 2 is annul on taken. Fetch is never held, and a not-taken transfer kills nothing and gives no redirect.
- R8: With annul on taken, a taken transfer kills every valid younger stage in the resolve cycle and redirects to the destination.
- R9: The interrupt mask is high from the decode cycle through the resolve cycle of an annul-on-taken transfer. It is never high under the other policies.
- R10: The redirect strobe lasts exactly one cycle, and the destination is fetched in the following cycle.
- R11: The policy is sampled in the cycle the transfer is in decode. Later changes of the policy input have no effect on that transfer.
- R12: A transfer that reaches decode while a delay-slot or annul-on-taken transfer is still pending raises the error flag for that cycle. It is not tracked, and it causes no redirect of its own.
- R13: A kill bit is never set for a stage that holds no valid instruction. The fetch hold and the interrupt mask are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Policy code: 0 flush, 1 delay slots, 2 annul on taken, 3 flush |
| stg_valid_i | input | DEPTH | Valid flag of stages 0 (fetch) to DEPTH-1 |
| dec_kind_i | input | 2 | Flow code of the decode-stage instruction: 0 none, 1 branch, 2 call, 3 return |
| ex_taken_i | input | 1 | Resolved outcome of the instruction in execute |
| ex_target_i | input | AW | Destination address of the instruction in execute |
| ex_seq_pc_i | input | AW | Sequential address following the instruction in execute |
| kill_o | output | DEPTH | Per-stage discard for stages 0 to DEPTH-1 |
| redirect_o | output | 1 | One-cycle fetch redirect strobe |
| redirect_pc_o | output | AW | Address to fetch next when redirecting, zero otherwise |
| fetch_stall_o | output | 1 | Hold fetch |
| irq_mask_o | output | 1 | Interrupts masked |
| slot_err_o | output | 1 | Transfer arrived in the shadow of a pending one |

## Verification
The bound checker watches several properties on every cycle:

- the redirect strobe never lasts more than one cycle;
- the fetch hold, once raised, stays up until the redirect;
- kills fall only on valid stages;
- the fetch hold and the interrupt mask are never high together;
- the error flag appears only with a valid decode instruction and never under a fetch hold.

Some behaviour can only be shown by the bench's pipeline model. It sweeps every policy code, every flow kind and both outcomes, with and without a policy change after decode. For each run it compares the retired address stream and its cycle spacing with arithmetic expectations. That comparison covers which instructions survive, the number of lost slots, the redirect address, and the length of the interrupt-mask window.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

    typedef enum logic [1:0] {
        M_FLUSH = 2'd0,
        M_DELAY = 2'd1,
        M_ANNUL = 2'd2
    } pol_e;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_JUMP = 2'd1,
        K_CALL = 2'd2,
        K_RET  = 2'd3
    } ctl_e;

    typedef struct packed {
        logic redirect;
        logic stall;
        logic irq_mask;
    } fetch_ctl_t;

    function automatic pol_e decode_policy(input logic [1:0] code);
        case (code)
            2'd1:    return M_DELAY;
            2'd2:    return M_ANNUL;
            default: return M_FLUSH;
        endcase
    endfunction

    function automatic logic is_flow(input logic [1:0] code);
        return ctl_e'(code) != K_NONE;
    endfunction

endpackage

// File: rtl/bsq_tracker.sv
module bsq_tracker
    import bsq_pkg::*;
#(
    parameter int DEPTH = 3,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dec_valid,
    input  logic          dec_flow,
    input  logic [1:0]    mode_code,
    output logic          active,
    output logic          resolve,
    output logic [CW-1:0] stage,
    output pol_e          policy,
    output logic          shadow_err
);

    typedef struct packed {
        logic          pend;
        logic [CW-1:0] age;
        pol_e          pol;
    } trk_t;

    trk_t trk_q;
    logic detect;

    assign detect     = dec_valid && dec_flow && !trk_q.pend;
    assign shadow_err = dec_valid && dec_flow && trk_q.pend && (trk_q.pol != M_FLUSH);
    assign active     = detect || trk_q.pend;
    assign stage      = trk_q.pend ? trk_q.age : CW'(1);
    assign policy     = trk_q.pend ? trk_q.pol : decode_policy(mode_code);
    assign resolve    = active && (stage == CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_q.pend <= 1'b0;
            trk_q.age  <= '0;
            trk_q.pol  <= M_FLUSH;
        end else if (detect) begin
            trk_q.pend <= 1'b1;
            trk_q.age  <= CW'(2);
            trk_q.pol  <= decode_policy(mode_code);
        end else if (trk_q.pend && (trk_q.age == CW'(DEPTH))) begin
            trk_q.pend <= 1'b0;
        end else if (trk_q.pend) begin
            trk_q.age  <= trk_q.age + CW'(1);
        end
    end

endmodule

// File: rtl/bsq_kill_mask.sv
module bsq_kill_mask #(
    parameter int DEPTH = 3,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0] stg_valid,
    input  logic [CW-1:0]    stage,
    input  logic             enable,
    output logic [DEPTH-1:0] kill
);

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        assign kill[s] = enable && stg_valid[s] && (stage > CW'(s));
    end

endmodule

// File: rtl/bsq_fetch_ctl.sv
module bsq_fetch_ctl
    import bsq_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          active,
    input  logic          resolve,
    input  pol_e          policy,
    input  logic          taken,
    input  logic [AW-1:0] target,
    input  logic [AW-1:0] seq_pc,
    output fetch_ctl_t    ctl,
    output logic [AW-1:0] redirect_pc
);

    logic flush_pol;

    assign flush_pol    = (policy == M_FLUSH);
    assign ctl.stall    = active && flush_pol;
    assign ctl.irq_mask = active && (policy == M_ANNUL);
    assign ctl.redirect = resolve && (flush_pol || taken);

    always_comb begin
        if (!ctl.redirect)
            redirect_pc = '0;
        else if (flush_pol && !taken)
            redirect_pc = seq_pc;
        else
            redirect_pc = target;
    end

endmodule

// File: rtl/branch_squash_ctl.sv
module branch_squash_ctl
    import bsq_pkg::*;
#(
    parameter int DEPTH = 3,
    parameter int AW    = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_i,
    input  logic [DEPTH-1:0] stg_valid_i,
    input  logic [1:0]       dec_kind_i,
    input  logic             ex_taken_i,
    input  logic [AW-1:0]    ex_target_i,
    input  logic [AW-1:0]    ex_seq_pc_i,
    output logic [DEPTH-1:0] kill_o,
    output logic             redirect_o,
    output logic [AW-1:0]    redirect_pc_o,
    output logic             fetch_stall_o,
    output logic             irq_mask_o,
    output logic             slot_err_o
);

    logic          active;
    logic          resolve;
    logic [CW-1:0] stage;
    pol_e          policy;
    logic          kill_en;
    fetch_ctl_t    fctl;

    bsq_tracker #(.DEPTH(DEPTH)) u_track (
        .clk        (clk),
        .rst        (rst),
        .dec_valid  (stg_valid_i[1]),
        .dec_flow   (is_flow(dec_kind_i)),
        .mode_code  (mode_i),
        .active     (active),
        .resolve    (resolve),
        .stage      (stage),
        .policy     (policy),
        .shadow_err (slot_err_o)
    );

    // flush discards younger work while pending; annul only on a taken outcome
    assign kill_en = active && ((policy == M_FLUSH) ||
                                ((policy == M_ANNUL) && resolve && ex_taken_i));

    bsq_kill_mask #(.DEPTH(DEPTH)) u_kill (
        .stg_valid (stg_valid_i),
        .stage     (stage),
        .enable    (kill_en),
        .kill      (kill_o)
    );

    bsq_fetch_ctl #(.AW(AW)) u_fetch (
        .active      (active),
        .resolve     (resolve),
        .policy      (policy),
        .taken       (ex_taken_i),
        .target      (ex_target_i),
        .seq_pc      (ex_seq_pc_i),
        .ctl         (fctl),
        .redirect_pc (redirect_pc_o)
    );

    assign redirect_o    = fctl.redirect;
    assign fetch_stall_o = fctl.stall;
    assign irq_mask_o    = fctl.irq_mask;

endmodule

// File: rtl/branch_squash_ctl_chk.sv
module branch_squash_ctl_chk #(
    parameter int DEPTH = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [DEPTH-1:0] stg_valid_i,
    input logic [DEPTH-1:0] kill_o,
    input logic             redirect_o,
    input logic             fetch_stall_o,
    input logic             irq_mask_o,
    input logic             slot_err_o
);

    p_strobe_single_r10: assert property (@(posedge clk) disable iff (rst)
        redirect_o |=> !redirect_o);

    p_kill_valid_r13: assert property (@(posedge clk) disable iff (rst)
        (kill_o & ~stg_valid_i) == '0);

    p_hold_mask_excl_r13: assert property (@(posedge clk) disable iff (rst)
        !(fetch_stall_o && irq_mask_o));

    p_hold_until_redirect_r3: assert property (@(posedge clk) disable iff (rst)
        (fetch_stall_o && !redirect_o) |=> fetch_stall_o);

    p_err_in_decode_r12: assert property (@(posedge clk) disable iff (rst)
        slot_err_o |-> stg_valid_i[1]);

    p_err_not_flush_r12: assert property (@(posedge clk) disable iff (rst)
        slot_err_o |-> !fetch_stall_o);

endmodule

bind branch_squash_ctl branch_squash_ctl_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/test_branch_squash_ctl.sv
module test_branch_squash_ctl;

    localparam int D     = 3;
    localparam int AW    = 16;
    localparam int CLK_P = 10;
    localparam int BR_A  = 5;
    localparam int TGT   = 40;
    localparam int NCYC  = 30;

    logic          clk = 1'b0;
    logic          rst;
    logic [1:0]    mode_i;
    logic [D-1:0]  stg_valid_i;
    logic [1:0]    dec_kind_i;
    logic          ex_taken_i;
    logic [AW-1:0] ex_target_i;
    logic [AW-1:0] ex_seq_pc_i;
    logic [D-1:0]  kill_o;
    logic          redirect_o;
    logic [AW-1:0] redirect_pc_o;
    logic          fetch_stall_o;
    logic          irq_mask_o;
    logic          slot_err_o;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    // program description for the current run
    int r_kind, r_taken, r_second;
    // pipeline model: stage 0 fetch .. stage D execute
    bit mv[D+1];
    int ma[D+1];
    int mpc;
    int ret_a[64];
    int ret_c[64];
    int nret;

    always #(CLK_P/2) clk = ~clk;

    branch_squash_ctl #(.DEPTH(D), .AW(AW)) i_branch_squash_ctl (
        .clk, .rst, .mode_i, .stg_valid_i, .dec_kind_i, .ex_taken_i,
        .ex_target_i, .ex_seq_pc_i, .kill_o, .redirect_o, .redirect_pc_o,
        .fetch_stall_o, .irq_mask_o, .slot_err_o
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int kind_at(input int a);
        if (a == BR_A) return r_kind;
        if (r_second != 0 && a == BR_A + 1) return 1;
        return 0;
    endfunction

    function automatic int taken_at(input int a);
        return (a == BR_A) ? r_taken : 1;
    endfunction

    function automatic int target_at(input int a);
        return (a == BR_A) ? TGT : 200;
    endfunction

    task automatic apply();
        for (int s = 0; s < D; s++) stg_valid_i[s] = mv[s];
        dec_kind_i  = mv[1] ? 2'(kind_at(ma[1])) : 2'd0;
        ex_taken_i  = (taken_at(ma[D]) != 0);
        ex_target_i = AW'(target_at(ma[D]));
        ex_seq_pc_i = AW'(ma[D] + 1);
    endtask

    // address of the k-th retired instruction after the transfer
    function automatic int exp_addr(input int em, input int tk, input int k);
        if (em == 0) return (tk != 0 ? TGT : BR_A + 1) + k - 1;
        if (em == 1) return (k <= D || tk == 0) ? BR_A + k : TGT + k - D - 1;
        return (tk != 0) ? TGT + k - 1 : BR_A + k;
    endfunction

    // cycles between the transfer retiring and the k-th following retirement
    function automatic int exp_gap(input int em, input int tk, input int k);
        if (em == 0) return D + k;
        if (em == 2 && tk != 0) return D + k;
        return k;
    endfunction

    task automatic run_one(input int m, input int kind, input int tk,
                           input int scr, input int sec, input bit first);
        int em, n_stall, n_irq, n_red, n_err, n_viol;
        bit sw;
        bit nv[D+1];
        int na[D+1];
        string rq;
        em = (m == 3) ? 0 : m;
        r_kind = kind; r_taken = tk; r_second = sec;
        n_stall = 0; n_irq = 0; n_red = 0; n_err = 0; n_viol = 0; nret = 0;
        sw = 0;
        for (int s = 0; s <= D; s++) begin mv[s] = 0; ma[s] = 0; end
        mpc = 0;
        mode_i = 2'(m);
        rst = 1'b1;
        apply();
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        for (int c = 0; c < NCYC; c++) begin
            @(negedge clk);
            if (first && c == 0)
                chk("R1", int'({kill_o, redirect_o, fetch_stall_o, irq_mask_o, slot_err_o}), 0);
            if (mv[D] && nret < 64) begin
                ret_a[nret] = ma[D];
                ret_c[nret] = c;
                nret++;
            end
            if (fetch_stall_o) n_stall++;
            if (irq_mask_o) n_irq++;
            if (redirect_o) n_red++;
            if (slot_err_o) n_err++;
            if (fetch_stall_o && irq_mask_o) n_viol++;
            for (int s = 0; s < D; s++) if (kill_o[s] && !mv[s]) n_viol++;
            if (scr != 0 && mv[1] && ma[1] == BR_A) sw = 1;
            for (int s = D; s >= 1; s--) begin
                nv[s] = mv[s-1] && !kill_o[s-1];
                na[s] = ma[s-1];
            end
            if (redirect_o) begin
                nv[0] = 1; na[0] = int'(redirect_pc_o); mpc = na[0] + 1;
            end else if (fetch_stall_o) begin
                nv[0] = 0; na[0] = 0;
            end else begin
                nv[0] = 1; na[0] = mpc; mpc++;
            end
            @(posedge clk);
            #1;
            for (int s = 0; s <= D; s++) begin mv[s] = nv[s]; ma[s] = na[s]; end
            apply();
            if (sw) mode_i = 2'((m + 1) % 4);
        end
        // instructions up to and including the transfer retire in order (R2)
        begin
            int bad;
            bad = 0;
            for (int i = 0; i <= BR_A; i++) if (i >= nret || ret_a[i] != i) bad++;
            chk("R2", bad, 0);
        end
        for (int k = 1; k <= 6; k++) begin
            if (scr != 0) rq = "R11";
            else if (em == 0) rq = "R4";
            else if (em == 1) rq = (k <= D) ? "R5" : "R6";
            else rq = (tk != 0) ? "R8" : "R7";
            if (BR_A + k < nret) begin
                chk(rq, ret_a[BR_A + k], exp_addr(em, tk, k));
                chk(rq, ret_c[BR_A + k] - ret_c[BR_A], exp_gap(em, tk, k));
            end else begin
                chk(rq, nret, BR_A + k + 1);
            end
        end
        chk("R3", n_stall, (em == 0) ? D : 0);
        chk("R9", n_irq, (em == 2) ? D : 0);
        chk("R10", n_red, (em == 0 || tk != 0) ? 1 : 0);
        chk("R12", n_err, (sec != 0) ? 1 : 0);
        chk("R13", n_viol, 0);
    endtask

    initial begin
        bit first;
        first = 1;
        rst = 1'b1;
        mode_i = 2'd0;
        stg_valid_i = '0;
        dec_kind_i = 2'd0;
        ex_taken_i = 1'b0;
        ex_target_i = '0;
        ex_seq_pc_i = '0;
        for (int m = 0; m < 4; m++)
            for (int kind = 1; kind < 4; kind++)
                for (int tk = 0; tk < 2; tk++)
                    for (int scr = 0; scr < 2; scr++) begin
                        run_one(m, kind, tk, scr, 0, first);
                        first = 0;
                    end
        // transfer in the shadow of a pending one
        for (int m = 1; m < 3; m++)
            for (int tk = 0; tk < 2; tk++)
                run_one(m, 1, tk, 0, 1, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

endmodule